// File: doc/BRIEF.md
# Shutdown Request Input Filter

This block watches an external active-low shutdown request pin and turns a qualifying request into a single-cycle pulse. It also keeps a sticky status bit. The pin is first passed through a two-stage synchronizer. A 2-bit detection-mode field then chooses how a request is recognised. Mode 00 is a plain falling-edge detector. The other three modes take samples of the pin at a rate derived from the block clock. They accept a request only once sixteen samples in a row have all been low.

The mode field is loaded through a simple write strobe. It can be loaded only once after a power-on reset, and later writes are dropped. The lock survives the soft reset, which clears only the detection state and the status bit. After each accepted request, the pin must be seen high again before another request can be raised.

Top module: `shdn_req_filter`

## Requirements
- R1: After power-on reset, `reqPulse` and `reqSticky` are 0 and the detection mode is 00 (edge).
- R2: In mode 00, a falling edge on `pinN` raises `reqPulse` at the third rising clock edge after the pin falls. Two of those edges are synchronizer stages and one is the output register.
- R3: Mode encodings are 01 for one sample every 8 clocks, 10 for every 16 clocks and 11 for every 128 clocks. In these modes a request is accepted on the 16th consecutive low sample, so with the pin held low the pulse comes between 15*D+2 and 16*D+3 clocks after the fall.
- R4: In a sampled mode, any high sample returns the run of low samples to zero. A low stretch that is broken by a high sample raises no pulse, and counting starts again from the next fall.
- R5: `reqPulse` is high for exactly one cycle per accepted request. While the pin stays low, no further pulse is raised. A new request is accepted only after the synchronized pin has been high.
- R6: `reqSticky` is set with each request pulse. It stays set until a soft reset (`rstN` low) or a power-on reset (`porN` low).
- R7: The first mode write after power-on reset takes effect and locks the field. Later writes are ignored, including writes made after a soft reset. Only `porN` clears the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the source of the sample rates |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears everything including the mode lock |
| rstN | input | 1 | Soft reset, active low, asynchronous; clears detection state and status only |
| pinN | input | 1 | Raw asynchronous shutdown request pin, active low |
| modeWrEn | input | 1 | Write strobe for the detection-mode field |
| modeWrData | input | 2 | Mode value written when `modeWrEn` is high |
| reqPulse | output | 1 | One-cycle request pulse |
| reqSticky | output | 1 | Sticky request status |

## Verification
A wrong sample-rate selection or a low-sample counter that does not clear shows up as a request pulse outside the latency window for the chosen mode. At the slowest rate this can be off by whole sample periods, up to about two thousand cycles. A broken re-arm flag shows up as a second pulse while the pin is still held low, within one sample period. A lock that fails to hold shows up on the first request after the late write, because its latency then matches the wrong divider. In edge mode, an extra or missing synchronizer stage moves the pulse off its exact third-edge slot.

// File: rtl/shdn_filt_pkg.sv
package shdn_filt_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_DIV_A = 2'b01,
    MODE_DIV_B = 2'b10,
    MODE_DIV_C = 2'b11
  } detMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic edgeMode;    // falling-edge detection selected
    logic sampleTick;  // take one pin sample this cycle
    logic restart;     // mode just written: drop the low-sample run
  } filtStrobe_t;

endpackage

// File: rtl/shdn_filt_ctrl.sv
module shdn_filt_ctrl
  import shdn_filt_pkg::*;
#(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        anyRstN,
  input  logic        modeWrEn,
  input  logic [1:0]  modeWrData,
  output filtStrobe_t strobe
);

  localparam int DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int DIV_MAX = (DIV_AB > DIV_C) ? DIV_AB : DIV_C;
  localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  detMode_e         modeQ;
  logic             lockedQ;
  logic             wrAccept;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;

  assign wrAccept = modeWrEn && !lockedQ;

  // mode field and write-once lock: power-on reset only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      modeQ   <= MODE_EDGE;
      lockedQ <= 1'b0;
    end else if (wrAccept) begin
      modeQ   <= detMode_e'(modeWrData);
      lockedQ <= 1'b1;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_DIV_A: preLimit = PRE_W'(DIV_A - 1);
      MODE_DIV_B: preLimit = PRE_W'(DIV_B - 1);
      MODE_DIV_C: preLimit = PRE_W'(DIV_C - 1);
      default:    preLimit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      preCnt <= '0;
    end else if (wrAccept || preCnt == preLimit) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign strobe.edgeMode   = (modeQ == MODE_EDGE);
  assign strobe.sampleTick = (modeQ != MODE_EDGE) && (preCnt == preLimit);
  assign strobe.restart    = wrAccept;

  // R7: once locked, the mode field never moves until power-on reset
  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!porN)
    lockedQ |=> $stable(modeQ));

  // R3: samples never come on back-to-back cycles in any sampled mode
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!anyRstN)
    strobe.sampleTick |=> !strobe.sampleTick);

endmodule

// File: rtl/shdn_filt_dp.sv
module shdn_filt_dp
  import shdn_filt_pkg::*;
#(
  parameter int SAMPLES     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        anyRstN,
  input  logic        pinN,
  input  filtStrobe_t strobe,
  output logic        reqPulse,
  output logic        reqSticky
);

  localparam int                CNT_W    = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SAMPLES - 1);

  logic [SYNC_STAGES-1:0] syncStg;
  logic                   pinSync;
  logic                   prevQ;
  logic                   armedQ;
  logic [CNT_W-1:0]       lowCnt;
  logic                   edgeHit;
  logic                   levelHit;
  logic                   fire;

  // synchronizer chain
  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) syncStg[0] <= 1'b1;
    else          syncStg[0] <= pinN;
  end

  for (genvar gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
    always_ff @(posedge clk or negedge anyRstN) begin
      if (!anyRstN) syncStg[gi] <= 1'b1;
      else          syncStg[gi] <= syncStg[gi-1];
    end
  end

  assign pinSync = syncStg[SYNC_STAGES-1];

  assign edgeHit  = strobe.edgeMode && prevQ && !pinSync;
  assign levelHit = !strobe.edgeMode && strobe.sampleTick && !pinSync &&
                    (lowCnt == CNT_LAST);
  assign fire     = armedQ && (edgeHit || levelHit);

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      prevQ     <= 1'b1;
      armedQ    <= 1'b0;
      lowCnt    <= '0;
      reqPulse  <= 1'b0;
      reqSticky <= 1'b0;
    end else begin
      prevQ    <= pinSync;
      reqPulse <= fire;
      if (fire)         reqSticky <= 1'b1;
      if (fire)         armedQ    <= 1'b0;
      else if (pinSync) armedQ    <= 1'b1;
      if (strobe.restart) begin
        lowCnt <= '0;
      end else if (strobe.sampleTick) begin
        if (pinSync)                lowCnt <= '0;
        else if (lowCnt != CNT_LAST) lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  // R5: a pulse lasts one cycle
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!anyRstN)
    reqPulse |=> !reqPulse);

  // R5: a pulse only follows an armed state (pin seen high since last request)
  assert_pulse_armed_R5: assert property (@(posedge clk) disable iff (!anyRstN)
    reqPulse |-> $past(armedQ));

  // R3: in sampled modes a pulse needs a full run of low samples
  assert_full_run_R3: assert property (@(posedge clk) disable iff (!anyRstN)
    (reqPulse && !$past(strobe.edgeMode)) |-> ($past(lowCnt) == CNT_LAST));

  // R6: status follows the pulse and then holds
  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!anyRstN)
    reqPulse |-> reqSticky);
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!anyRstN)
    reqSticky |=> reqSticky);

endmodule

// File: rtl/shdn_req_filter.sv
module shdn_req_filter
  import shdn_filt_pkg::*;
#(
  parameter int DIV_A       = 8,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 128,
  parameter int SAMPLES     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       pinN,
  input  logic       modeWrEn,
  input  logic [1:0] modeWrData,
  output logic       reqPulse,
  output logic       reqSticky
);

  logic        anyRstN;
  filtStrobe_t strobe;

  assign anyRstN = porN & rstN;

  shdn_filt_ctrl #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) ctrl_i (
    .clk        (clk),
    .porN       (porN),
    .anyRstN    (anyRstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .strobe     (strobe)
  );

  shdn_filt_dp #(
    .SAMPLES(SAMPLES), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .anyRstN   (anyRstN),
    .pinN      (pinN),
    .strobe    (strobe),
    .reqPulse  (reqPulse),
    .reqSticky (reqSticky)
  );

  // R1: nothing is reported straight out of power-on reset
  assert_quiet_after_por_R1: assert property (@(posedge clk) disable iff (!anyRstN)
    $rose(porN) |-> (!reqPulse && !reqSticky));

endmodule

// File: tb/shdn_req_filter_tb_top.sv
module shdn_req_filter_tb_top;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       rstN = 1'b1;
  logic       pinN = 1'b1;
  logic       modeWrEn = 1'b0;
  logic [1:0] modeWrData = 2'b00;
  logic       reqPulse;
  logic       reqSticky;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  shdn_req_filter dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .pinN(pinN),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .reqPulse(reqPulse), .reqSticky(reqSticky)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    porN = 1'b0; rstN = 1'b1; pinN = 1'b1; modeWrEn = 1'b0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic soft_rst();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk);
    modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  // counts rising edges from a negedge drive until reqPulse or limit
  task automatic wait_pulse(input int limit, output int n, output bit seen);
    seen = 1'b0;
    n = 0;
    while (n < limit && !seen) begin
      @(posedge clk); #1;
      n++;
      if (reqPulse) seen = 1'b1;
    end
  endtask

  task automatic count_pulses(input int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      if (reqPulse) c++;
    end
  endtask

  task automatic t_reset();
    do_por();
    chk(reqPulse == 1'b0, "R1", "pulse after por", int'(reqPulse), 0);
    chk(reqSticky == 1'b0, "R1", "sticky after por", int'(reqSticky), 0);
  endtask

  task automatic t_edge();
    int n; bit seen; int c;
    // default mode 00 is edge detection (R1, R2)
    @(negedge clk); pinN = 1'b0;
    wait_pulse(20, n, seen);
    chk(seen && n == 3, "R2", "edge latency (default mode R1)", n, 3);
    @(posedge clk); #1;
    chk(reqPulse == 1'b0, "R5", "pulse width", int'(reqPulse), 0);
    chk(reqSticky == 1'b1, "R6", "sticky set", int'(reqSticky), 1);
    count_pulses(40, c);
    chk(c == 0, "R5", "no repeat while low", c, 0);
    @(negedge clk); pinN = 1'b1;
    repeat (5) @(negedge clk);
    pinN = 1'b0;
    wait_pulse(20, n, seen);
    chk(seen && n == 3, "R5", "re-armed after high", n, 3);
    @(negedge clk); pinN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_soft_edge();
    int n; bit seen;
    soft_rst();
    chk(reqSticky == 1'b0, "R6", "sticky cleared by soft reset", int'(reqSticky), 0);
    @(negedge clk); pinN = 1'b0;
    wait_pulse(20, n, seen);
    chk(seen && n == 3, "R2", "edge after soft reset", n, 3);
    @(negedge clk); pinN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_filter(input logic [1:0] m, input int d, input bit doPor,
                          input string tag);
    int n; bit seen; int c;
    if (doPor) begin
      do_por();
      wr_mode(m);
    end
    repeat (3) @(negedge clk);
    pinN = 1'b0;
    wait_pulse(16 * d + 20, n, seen);
    chk(seen && n >= 15 * d + 2 && n <= 16 * d + 3, tag, "filtered latency",
        n, 15 * d + 2);
    count_pulses(3 * d + 40, c);
    chk(c == 0, "R5", "single pulse in sampled mode", c, 0);
    @(negedge clk); pinN = 1'b1;
    repeat (2 * d) @(negedge clk);
  endtask

  task automatic t_glitch();
    int n; bit seen;
    // mode 01 (every 8 clocks) already locked
    @(negedge clk); pinN = 1'b0;
    wait_pulse(80, n, seen);
    chk(!seen, "R4", "no pulse on short low run", int'(seen), 0);
    @(negedge clk); pinN = 1'b1;
    wait_pulse(24, n, seen);
    chk(!seen, "R4", "no pulse during high break", int'(seen), 0);
    @(negedge clk); pinN = 1'b0;
    wait_pulse(16 * 8 + 20, n, seen);
    chk(seen && n >= 15 * 8 + 2 && n <= 16 * 8 + 3, "R4",
        "run restarts after high sample", n, 15 * 8 + 2);
    @(negedge clk); pinN = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_lock();
    do_por();
    wr_mode(2'b01);
    wr_mode(2'b11);            // ignored: lock set
    t_filter(2'b01, 8, 1'b0, "R7");
    t_glitch();
    soft_rst();
    wr_mode(2'b10);            // still ignored after soft reset
    t_filter(2'b01, 8, 1'b0, "R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    t_reset();
    t_edge();
    t_soft_edge();
    t_lock();
    t_filter(2'b10, 16, 1'b1, "R3");
    t_filter(2'b11, 128, 1'b1, "R3");   // new por also frees the lock (R7)
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule